// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block is the transaction layer of an SMBus host. Software loads a small register set (target address byte with its direction bit, command byte, two data bytes) and a byte queue, selects one of three protocols and pulses a start input. The block then walks the bus through the right sequence by issuing one operation at a time to a byte-level bus engine over a request/acknowledge handshake. The operations are start, repeated start, stop, write byte, and read byte with ACK or NACK. Bit timing, clock stretching, arbitration and PEC are the engine's concern or are not handled.

Three protocols are supported: a Process Call (word write joined to a word read by a repeated start), a Block Write and a Block Read. Block transfers move a programmed number of bytes, 1 to 32, through a byte queue. The queue holds up to 32 bytes when deep mode is selected. Otherwise it holds a single byte, and the transfer pauses for software service after each byte. Completion, errors and service requests are reported through flags and a single interrupt line.

Top module: `smbus_cmd_seq`

## Requirements
- R1: A Process Call (proto code 0) issues, in order: START, WRITE of {addr[7:1],0}, WRITE command, WRITE data0, WRITE data1, RSTART, WRITE {addr[7:1],1}, READ_ACK, READ_NACK, STOP. There is no second command byte and no stop between the two phases. Operation codes on eng_op are: 1 START, 2 RSTART, 3 STOP, 4 WRITE, 5 READ_ACK, 6 READ_NACK.
- R2: In a Process Call, the first byte read replaces data0 and the second byte read replaces data1.
- R3: A Process Call whose address register bit 0 (direction) is 1 is refused, and so is proto code 3. In both cases err sets on the next cycle, busy stays low and no bus operation is issued.
- R4: A Block Write (proto code 1) issues START, WRITE {addr[7:1],0}, WRITE command, WRITE count, then one WRITE per queued byte in queue order, then STOP. The count sent is the value of data0 at start.
- R5: For either block protocol, a data0 value of 0 or above 32 is refused: err sets on the next cycle, busy stays low and no bus operation is issued.
- R6: A Block Read (proto code 2) issues START, WRITE {addr[7:1],0}, WRITE command, RSTART, WRITE {addr[7:1],1}, then reads a byte count and then exactly data0 data bytes. The count is taken from data0 at start, not from the device. The count byte received is stored in data0 and the data bytes are queued in arrival order. The queue is emptied when a Block Read starts.
- R7: In a Block Read, the count byte and every data byte except the last are read with ACK. The last data byte is read with NACK and is followed by STOP.
- R8: With deep mode on (buf32_en=1), the queue holds up to 32 bytes and irq stays low for the whole transfer. It rises only when done or err sets at the end.
- R9: With deep mode off, the queue holds one byte. A block transfer stalls with irq high while it waits for software to write the next payload byte or to read the received byte, and resumes once that is done.
- R10: A device NACK on any byte the host writes ends the transaction with STOP, sets err and leaves done clear.
- R11: A start pulse while busy is high has no effect on the transaction in progress.
- R12: busy is high from the cycle after an accepted start until the STOP is acknowledged. At that point done sets. Writing 1 to stat_clr bit 0 clears done, and writing 1 to bit 1 clears err. No bus request is made while busy is low.
- R13: A bus request, its operation code and its write data stay unchanged until the engine acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | 0 address byte, 1 command, 2 data0, 3 data1, 4 push to byte queue |
| reg_wr_data | input | 8 | Register write data |
| go | input | 1 | Start pulse, taken only when idle |
| proto | input | 2 | 0 Process Call, 1 Block Write, 2 Block Read, 3 refused |
| buf32_en | input | 1 | Deep 32-byte queue mode |
| stat_clr | input | 2 | Write-one-to-clear: bit 0 done, bit 1 err |
| data0_q | output | 8 | Data 0 register |
| data1_q | output | 8 | Data 1 register |
| blk_rd_en | input | 1 | Pop the byte queue head |
| blk_rd_data | output | 8 | Byte queue head |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction completed |
| err | output | 1 | Transaction refused or aborted |
| irq | output | 1 | done, err, or byte service needed in single-byte mode |
| eng_req | output | 1 | Bus operation request |
| eng_op | output | 3 | Requested operation code |
| eng_wdata | output | 8 | Byte to write |
| eng_ack | input | 1 | Engine finished the operation (one-cycle pulse) |
| eng_rdata | input | 8 | Byte read, valid with eng_ack |
| eng_nack | input | 1 | Device NACKed the written byte, valid with eng_ack |

## Verification
Several properties are checked on every cycle: request stability until acknowledge, silence on the bus while idle, refusal of a Process Call with the read bit set or an illegal block count, queue level within the selected depth, a quiet interrupt during deep-mode transfers, and done never rising together with err. Other behaviours can only be shown by the bench scenarios against a scoreboard of expected operations. These are the exact operation order of each protocol, the ACK/NACK choice on reads, the data landing in data0, data1 and the queue, the single-byte service stalls, the abort on a device NACK, and a start pulse during a transfer leaving that transfer untouched.

// File: rtl/smbus_seq_pkg.sv
// Shared encodings for the SMBus host command sequencer.
// Assumes: operation and selector codes are fixed by the block's port contract.
package smbus_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_START   = 3'd1,
        OP_RSTART  = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_RD_ACK  = 3'd5,
        OP_RD_NACK = 3'd6
    } bus_op_e;

    typedef enum logic [1:0] {
        PROTO_PCALL  = 2'd0,
        PROTO_BWRITE = 2'd1,
        PROTO_BREAD  = 2'd2,
        PROTO_RSVD   = 2'd3
    } proto_e;

    typedef enum logic [2:0] {
        SEL_ADDR  = 3'd0,
        SEL_CMD   = 3'd1,
        SEL_DATA0 = 3'd2,
        SEL_DATA1 = 3'd3,
        SEL_BLOCK = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/smbus_byte_fifo.sv
// Byte queue for block payloads with a selectable capacity.
// Does: first-in first-out storage of DEPTH entries. When cap_one is set,
// it reports full at one entry, so it acts as a single-byte buffer.
// Assumes: pushes while full and pops while empty are dropped; flush wins
// over a push or pop in the same cycle.
module smbus_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             cap_one,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_ptr;
    logic [LW-1:0]    cnt;
    logic             do_push;
    logic             do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (cnt == '0);
    assign full    = cap_one ? (cnt != '0) : (cnt == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign level   = cnt;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            if (do_push && !do_pop)      cnt <= cnt + LW'(1);
            else if (do_pop && !do_push) cnt <= cnt - LW'(1);
        end
    end

    // Payload storage, no reset needed.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/smbus_seq_ctrl.sv
// Transaction sequencer for Process Call, Block Write and Block Read.
// Does: checks a start request and walks a state machine that issues one
// bus operation at a time and waits for the engine's acknowledge. A NACK on
// any written byte diverts to STOP and reports an error.
// Assumes: eng_ack is a one-cycle pulse answering a held request; eng_nack
// is meaningful only with eng_ack on a WRITE.
module smbus_seq_ctrl
    import smbus_seq_pkg::*;
#(
    parameter int MAX_COUNT = 32,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [1:0] proto_i,
    input  logic [7:0] addr_byte,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] data0,
    input  logic [7:0] data1,
    input  logic [7:0] fifo_head,
    input  logic       fifo_empty,
    input  logic       fifo_full,
    input  logic       eng_ack,
    input  logic       eng_nack,
    output logic       eng_req,
    output bus_op_e    eng_op,
    output logic [7:0] eng_wdata,
    output logic       busy,
    output logic       wait_data,
    output logic       set_done,
    output logic       set_err,
    output logic       wr_d0,
    output logic       wr_d1,
    output logic       fifo_push,
    output logic       fifo_pop,
    output logic       fifo_flush
);

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR_W, S_CMD, S_PC_D0, S_PC_D1, S_BW_CNT,
        S_BW_DATA, S_RSTART, S_ADDR_R, S_PC_R0, S_PC_R1, S_BR_CNT,
        S_BR_DATA, S_STOP
    } state_e;

    state_e        state;
    proto_e        proto_q;
    proto_e        proto_in;
    logic [CW-1:0] remain;
    logic          abort_q;
    logic          legal;
    logic          accept;
    logic          acked;
    logic          last_byte;

    assign proto_in  = proto_e'(proto_i);
    assign last_byte = (remain == CW'(1));

    // Decide whether a start request may run.
    always_comb begin
        unique case (proto_in)
            PROTO_PCALL:               legal = !addr_byte[0];
            PROTO_BWRITE, PROTO_BREAD: legal = (data0 != 8'd0) && (data0 <= 8'(MAX_COUNT));
            default:                   legal = 1'b0;
        endcase
    end

    // Operation presented to the engine in each state.
    always_comb begin
        eng_op    = OP_NONE;
        eng_wdata = 8'd0;
        eng_req   = 1'b1;
        unique case (state)
            S_START:   eng_op = OP_START;
            S_ADDR_W:  begin eng_op = OP_WRITE; eng_wdata = {addr_byte[7:1], 1'b0}; end
            S_CMD:     begin eng_op = OP_WRITE; eng_wdata = cmd_byte; end
            S_PC_D0:   begin eng_op = OP_WRITE; eng_wdata = data0; end
            S_PC_D1:   begin eng_op = OP_WRITE; eng_wdata = data1; end
            S_BW_CNT:  begin eng_op = OP_WRITE; eng_wdata = 8'(remain); end
            S_BW_DATA: begin eng_op = OP_WRITE; eng_wdata = fifo_head; eng_req = !fifo_empty; end
            S_RSTART:  eng_op = OP_RSTART;
            S_ADDR_R:  begin eng_op = OP_WRITE; eng_wdata = {addr_byte[7:1], 1'b1}; end
            S_PC_R0:   eng_op = OP_RD_ACK;
            S_PC_R1:   eng_op = OP_RD_NACK;
            S_BR_CNT:  eng_op = OP_RD_ACK;
            S_BR_DATA: begin eng_op = last_byte ? OP_RD_NACK : OP_RD_ACK; eng_req = !fifo_full; end
            S_STOP:    eng_op = OP_STOP;
            default:   eng_req = 1'b0;
        endcase
    end

    assign accept     = (state == S_IDLE) && go && legal;
    assign acked      = eng_req && eng_ack;
    assign busy       = (state != S_IDLE);
    assign wait_data  = ((state == S_BW_DATA) && fifo_empty) || ((state == S_BR_DATA) && fifo_full);
    assign set_done   = acked && (state == S_STOP) && !abort_q;
    assign set_err    = (acked && (state == S_STOP) && abort_q) || ((state == S_IDLE) && go && !legal);
    assign wr_d0      = acked && ((state == S_PC_R0) || (state == S_BR_CNT));
    assign wr_d1      = acked && (state == S_PC_R1);
    assign fifo_push  = acked && (state == S_BR_DATA);
    assign fifo_pop   = acked && (state == S_BW_DATA);
    assign fifo_flush = accept && (proto_in == PROTO_BREAD);

    // State advance on start acceptance and on each acknowledged operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            proto_q <= PROTO_PCALL;
            remain  <= '0;
            abort_q <= 1'b0;
        end else if (accept) begin
            state   <= S_START;
            proto_q <= proto_in;
            remain  <= CW'(data0);
            abort_q <= 1'b0;
        end else if (acked) begin
            if ((eng_op == OP_WRITE) && eng_nack) begin
                abort_q <= 1'b1;
                state   <= S_STOP;
            end else begin
                unique case (state)
                    S_START:  state <= S_ADDR_W;
                    S_ADDR_W: state <= S_CMD;
                    S_CMD: begin
                        unique case (proto_q)
                            PROTO_PCALL:  state <= S_PC_D0;
                            PROTO_BWRITE: state <= S_BW_CNT;
                            default:      state <= S_RSTART;
                        endcase
                    end
                    S_PC_D0:  state <= S_PC_D1;
                    S_PC_D1:  state <= S_RSTART;
                    S_BW_CNT: state <= S_BW_DATA;
                    S_BW_DATA, S_BR_DATA: begin
                        remain <= remain - CW'(1);
                        if (last_byte) state <= S_STOP;
                    end
                    S_RSTART: state <= S_ADDR_R;
                    S_ADDR_R: state <= (proto_q == PROTO_PCALL) ? S_PC_R0 : S_BR_CNT;
                    S_PC_R0:  state <= S_PC_R1;
                    S_PC_R1:  state <= S_STOP;
                    S_BR_CNT: state <= S_BR_DATA;
                    S_STOP:   state <= S_IDLE;
                    default:  state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/smbus_cmd_seq.sv
// SMBus host command sequencer, top level.
// Does: holds the address, command and two data registers, the block byte
// queue and the status flags, and connects them to the transaction sequencer.
// Assumes: registers are not rewritten by software while busy; buf32_en is
// changed only while idle with the queue empty.
module smbus_cmd_seq
    import smbus_seq_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int LW = $clog2(BUF_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [2:0] reg_wr_sel,
    input  logic [7:0] reg_wr_data,
    input  logic       go,
    input  logic [1:0] proto,
    input  logic       buf32_en,
    input  logic [1:0] stat_clr,
    output logic [7:0] data0_q,
    output logic [7:0] data1_q,
    input  logic       blk_rd_en,
    output logic [7:0] blk_rd_data,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic       irq,
    output logic       eng_req,
    output logic [2:0] eng_op,
    output logic [7:0] eng_wdata,
    input  logic       eng_ack,
    input  logic [7:0] eng_rdata,
    input  logic       eng_nack
);

    logic [7:0]    addr_q;
    logic [7:0]    cmd_q;
    logic          done_q;
    logic          err_q;
    bus_op_e       seq_op;
    logic          wait_data;
    logic          set_done;
    logic          set_err;
    logic          wr_d0;
    logic          wr_d1;
    logic          seq_push;
    logic          seq_pop;
    logic          q_flush;
    logic          q_push;
    logic [7:0]    q_push_data;
    logic          q_pop;
    logic [7:0]    q_head;
    logic [LW-1:0] buf_level;
    logic          q_full;
    logic          q_empty;
    logic          sw_push;

    assign sw_push     = reg_wr_en && (reg_wr_sel == SEL_BLOCK);
    assign q_push      = seq_push || sw_push;
    assign q_push_data = seq_push ? eng_rdata : reg_wr_data;
    assign q_pop       = seq_pop || blk_rd_en;

    // Software-visible configuration and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= 8'd0;
            cmd_q   <= 8'd0;
            data0_q <= 8'd0;
            data1_q <= 8'd0;
        end else begin
            if (reg_wr_en && (reg_wr_sel == SEL_ADDR)) addr_q <= reg_wr_data;
            if (reg_wr_en && (reg_wr_sel == SEL_CMD))  cmd_q  <= reg_wr_data;
            if (wr_d0)                                        data0_q <= eng_rdata;
            else if (reg_wr_en && (reg_wr_sel == SEL_DATA0)) data0_q <= reg_wr_data;
            if (wr_d1)                                        data1_q <= eng_rdata;
            else if (reg_wr_en && (reg_wr_sel == SEL_DATA1)) data1_q <= reg_wr_data;
        end
    end

    // Completion and error flags, set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (set_done)         done_q <= 1'b1;
            else if (stat_clr[0]) done_q <= 1'b0;
            if (set_err)          err_q  <= 1'b1;
            else if (stat_clr[1]) err_q  <= 1'b0;
        end
    end

    assign done        = done_q;
    assign err         = err_q;
    assign irq         = done_q || err_q || (!buf32_en && wait_data);
    assign eng_op      = seq_op;
    assign blk_rd_data = q_head;

    smbus_byte_fifo #(
        .DEPTH (BUF_DEPTH),
        .WIDTH (8)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (q_flush),
        .cap_one   (!buf32_en),
        .push      (q_push),
        .push_data (q_push_data),
        .pop       (q_pop),
        .head      (q_head),
        .level     (buf_level),
        .full      (q_full),
        .empty     (q_empty)
    );

    smbus_seq_ctrl #(
        .MAX_COUNT (BUF_DEPTH)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .proto_i    (proto),
        .addr_byte  (addr_q),
        .cmd_byte   (cmd_q),
        .data0      (data0_q),
        .data1      (data1_q),
        .fifo_head  (q_head),
        .fifo_empty (q_empty),
        .fifo_full  (q_full),
        .eng_ack    (eng_ack),
        .eng_nack   (eng_nack),
        .eng_req    (eng_req),
        .eng_op     (seq_op),
        .eng_wdata  (eng_wdata),
        .busy       (busy),
        .wait_data  (wait_data),
        .set_done   (set_done),
        .set_err    (set_err),
        .wr_d0      (wr_d0),
        .wr_d1      (wr_d1),
        .fifo_push  (seq_push),
        .fifo_pop   (seq_pop),
        .fifo_flush (q_flush)
    );

endmodule

// File: rtl/smbus_cmd_seq_chk.sv
// Property checker for the SMBus host command sequencer, bound to the top.
// Does: watches the engine handshake, the refusal rules, queue depth and
// interrupt behaviour on every cycle.
module smbus_cmd_seq_chk #(
    parameter int DEPTH = 32,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          go,
    input logic [1:0]    proto,
    input logic [7:0]    addr_byte,
    input logic [7:0]    data0,
    input logic          buf32_en,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          irq,
    input logic          eng_req,
    input logic [2:0]    eng_op,
    input logic [7:0]    eng_wdata,
    input logic          eng_ack,
    input logic [LW-1:0] level
);

    // R13: a pending request holds its operation and data until acknowledged.
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata)));

    // R12: nothing is requested from the engine while idle.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_req);

    // R3: a Process Call with the read bit set is refused at once.
    p_pc_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && (proto == 2'd0) && addr_byte[0]) |=> (err && !busy));

    // R5: an illegal block count is refused at once.
    p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && ((proto == 2'd1) || (proto == 2'd2)) &&
         ((data0 == 8'd0) || (data0 > 8'(DEPTH)))) |=> (err && !busy));

    // R9: the queue never holds more than the selected capacity.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (buf32_en ? LW'(DEPTH) : LW'(1)));

    // R8: in deep mode the interrupt comes only from done or err.
    p_irq_mode32_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && buf32_en && irq) |-> (done || err));

    // R10: completion and failure never rise together.
    p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$rose(err));

endmodule

bind smbus_cmd_seq smbus_cmd_seq_chk #(.DEPTH(BUF_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .proto     (proto),
    .addr_byte (addr_q),
    .data0     (data0_q),
    .buf32_en  (buf32_en),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .irq       (irq),
    .eng_req   (eng_req),
    .eng_op    (eng_op),
    .eng_wdata (eng_wdata),
    .eng_ack   (eng_ack),
    .level     (buf_level)
);

// File: tb/smbus_cmd_seq_test.sv
// Scoreboard bench: scenario tasks queue the expected bus operations, and a
// negedge engine model pops and compares each one as the design requests it.
module smbus_cmd_seq_test;
    import smbus_seq_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [2:0] reg_wr_sel = 3'd0;
    logic [7:0] reg_wr_data = 8'd0;
    logic       go = 1'b0;
    logic [1:0] proto = 2'd0;
    logic       buf32_en = 1'b1;
    logic [1:0] stat_clr = 2'd0;
    logic [7:0] data0_q, data1_q, blk_rd_data, eng_wdata;
    logic       blk_rd_en = 1'b0;
    logic       busy, done, err, irq, eng_req;
    logic [2:0] eng_op;
    logic       eng_ack = 1'b0;
    logic [7:0] eng_rdata = 8'd0;
    logic       eng_nack = 1'b0;

    int errors = 0;
    int checks = 0;
    int bus_ops = 0;
    int wr_cnt = 0;
    int nack_at = -1;
    bit irq_busy_seen = 1'b0;
    logic [10:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  rd_q[$];

    // 200 MHz: 5 ns period (2 + 3 time units).
    always begin
        #2 clk = 1'b1;
        #3 clk = 1'b0;
    end

    smbus_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .go(go), .proto(proto), .buf32_en(buf32_en),
        .stat_clr(stat_clr), .data0_q(data0_q), .data1_q(data1_q),
        .blk_rd_en(blk_rd_en), .blk_rd_data(blk_rd_data), .busy(busy),
        .done(done), .err(err), .irq(irq), .eng_req(eng_req), .eng_op(eng_op),
        .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .eng_nack(eng_nack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Engine model and scoreboard monitor.
    always @(negedge clk) begin
        if (!rst_n || eng_ack) begin
            eng_ack  = 1'b0;
            eng_nack = 1'b0;
        end else if (eng_req) begin
            logic [10:0] e;
            string t;
            eng_ack  = 1'b1;
            eng_nack = 1'b0;
            bus_ops++;
            if (eng_op == OP_START) wr_cnt = 0;
            if (eng_op == OP_WRITE) begin
                if (wr_cnt == nack_at) eng_nack = 1'b1;
                wr_cnt++;
            end
            if ((eng_op == OP_RD_ACK) || (eng_op == OP_RD_NACK))
                eng_rdata = (rd_q.size() != 0) ? rd_q.pop_front() : 8'hEE;
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected bus op", int'(eng_op), 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(eng_op == e[10:8], t, int'(eng_op), int'(e[10:8]));
                if (e[10:8] == OP_WRITE)
                    chk(eng_wdata == e[7:0], t, int'(eng_wdata), int'(e[7:0]));
            end
        end
    end

    always @(negedge clk) begin
        if (busy && buf32_en && irq) irq_busy_seen = 1'b1;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic expect_op(input bus_op_e op, input logic [7:0] d, input string tag);
        exp_q.push_back({op, d});
        tag_q.push_back(tag);
    endtask

    task automatic wr_reg(input reg_sel_e sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic start(input proto_e p);
        @(negedge clk);
        go = 1'b1; proto = p;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        stat_clr = 2'b11;
        @(negedge clk);
        stat_clr = 2'b00;
    endtask

    task automatic pop_check(input logic [7:0] exp, input string tag);
        @(negedge clk);
        chk(blk_rd_data == exp, tag, int'(blk_rd_data), int'(exp));
        blk_rd_en = 1'b1;
        @(negedge clk);
        blk_rd_en = 1'b0;
    endtask

    initial begin
        int ops0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R12).
        chk(!busy && !done && !err, "R12 reset flags", {busy, done, err}, 0);
        chk(!irq && !eng_req, "R12 reset irq/req", {irq, eng_req}, 0);

        // Process Call (R1, R2, R12).
        wr_reg(SEL_ADDR, 8'hA0); wr_reg(SEL_CMD, 8'hA5);
        wr_reg(SEL_DATA0, 8'h12); wr_reg(SEL_DATA1, 8'h34);
        rd_q.push_back(8'h9A); rd_q.push_back(8'hBC);
        expect_op(OP_START, 0, "R1 start"); expect_op(OP_WRITE, 8'hA0, "R1 addr w");
        expect_op(OP_WRITE, 8'hA5, "R1 cmd"); expect_op(OP_WRITE, 8'h12, "R1 d0");
        expect_op(OP_WRITE, 8'h34, "R1 d1"); expect_op(OP_RSTART, 0, "R1 rstart");
        expect_op(OP_WRITE, 8'hA1, "R1 addr r"); expect_op(OP_RD_ACK, 0, "R1 rd0");
        expect_op(OP_RD_NACK, 0, "R1 rd1"); expect_op(OP_STOP, 0, "R1 stop");
        start(PROTO_PCALL);
        chk(busy, "R12 busy during transfer", busy, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R1 all ops issued", exp_q.size(), 0);
        chk(done && !err, "R12 done set", {done, err}, 2);
        chk(data0_q == 8'h9A, "R2 data0 result", data0_q, 8'h9A);
        chk(data1_q == 8'hBC, "R2 data1 result", data1_q, 8'hBC);
        @(negedge clk); stat_clr = 2'b01; @(negedge clk); stat_clr = 2'b00;
        chk(!done && !irq, "R12 done W1C", {done, irq}, 0);

        // Process Call with read bit set, and reserved code (R3).
        wr_reg(SEL_ADDR, 8'hA1);
        ops0 = bus_ops;
        start(PROTO_PCALL);
        chk(err && !busy, "R3 refuse rw=1", {err, busy}, 2);
        repeat (5) @(negedge clk);
        chk(bus_ops == ops0, "R3 no bus op", bus_ops, ops0);
        @(negedge clk); stat_clr = 2'b10; @(negedge clk); stat_clr = 2'b00;
        chk(!err, "R12 err W1C", err, 0);
        wr_reg(SEL_ADDR, 8'hA0);
        start(PROTO_RSVD);
        chk(err && !busy && bus_ops == ops0, "R3 refuse reserved", {err, busy}, 2);
        clear_flags();

        // Illegal block counts (R5).
        wr_reg(SEL_DATA0, 8'd0);
        start(PROTO_BWRITE);
        chk(err && !busy, "R5 count 0", {err, busy}, 2);
        clear_flags();
        wr_reg(SEL_DATA0, 8'd33);
        start(PROTO_BREAD);
        chk(err && !busy, "R5 count 33", {err, busy}, 2);
        chk(bus_ops == ops0, "R5 no bus op", bus_ops, ops0);
        clear_flags();

        // Block Write, deep mode, 5 bytes, with a start pulse while busy (R4, R8, R11).
        wr_reg(SEL_DATA0, 8'd5); wr_reg(SEL_CMD, 8'h3C);
        for (int i = 0; i < 5; i++) wr_reg(SEL_BLOCK, 8'(8'h11 * (i + 1)));
        expect_op(OP_START, 0, "R4 start"); expect_op(OP_WRITE, 8'hA0, "R4 addr");
        expect_op(OP_WRITE, 8'h3C, "R4 cmd"); expect_op(OP_WRITE, 8'd5, "R4 count");
        for (int i = 0; i < 5; i++) expect_op(OP_WRITE, 8'(8'h11 * (i + 1)), "R4 data");
        expect_op(OP_STOP, 0, "R4 stop");
        irq_busy_seen = 1'b0;
        ops0 = bus_ops;
        start(PROTO_BWRITE);
        repeat (3) @(negedge clk);
        go = 1'b1; proto = 2'd2;
        @(negedge clk);
        go = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0 && bus_ops - ops0 == 10, "R11 transfer unaffected", bus_ops - ops0, 10);
        chk(!irq_busy_seen, "R8 irq quiet while busy", irq_busy_seen, 0);
        chk(done && irq, "R8 irq at done", {done, irq}, 3);
        clear_flags();

        // Block Write, deep mode, 32 bytes boundary (R4, R8).
        wr_reg(SEL_DATA0, 8'd32);
        for (int i = 0; i < 32; i++) wr_reg(SEL_BLOCK, 8'(i * 7 + 1));
        expect_op(OP_START, 0, "R4 start"); expect_op(OP_WRITE, 8'hA0, "R4 addr");
        expect_op(OP_WRITE, 8'h3C, "R4 cmd"); expect_op(OP_WRITE, 8'd32, "R4 count 32");
        for (int i = 0; i < 32; i++) expect_op(OP_WRITE, 8'(i * 7 + 1), "R4 data 32");
        expect_op(OP_STOP, 0, "R4 stop");
        irq_busy_seen = 1'b0;
        start(PROTO_BWRITE);
        wait_idle();
        chk(exp_q.size() == 0 && done, "R4 32-byte write done", exp_q.size(), 0);
        chk(!irq_busy_seen, "R8 irq quiet 32 bytes", irq_busy_seen, 0);
        clear_flags();

        // Block Read, deep mode, programmed 4, device claims 9 (R6, R7).
        wr_reg(SEL_DATA0, 8'd4);
        rd_q.push_back(8'h09);
        for (int i = 0; i < 4; i++) rd_q.push_back(8'(8'hF0 + i));
        expect_op(OP_START, 0, "R6 start"); expect_op(OP_WRITE, 8'hA0, "R6 addr w");
        expect_op(OP_WRITE, 8'h3C, "R6 cmd"); expect_op(OP_RSTART, 0, "R6 rstart");
        expect_op(OP_WRITE, 8'hA1, "R6 addr r"); expect_op(OP_RD_ACK, 0, "R7 count ack");
        for (int i = 0; i < 3; i++) expect_op(OP_RD_ACK, 0, "R7 data ack");
        expect_op(OP_RD_NACK, 0, "R7 last nack"); expect_op(OP_STOP, 0, "R7 stop");
        start(PROTO_BREAD);
        wait_idle();
        chk(exp_q.size() == 0 && done, "R6 read done", exp_q.size(), 0);
        chk(data0_q == 8'h09, "R6 count byte in data0", data0_q, 8'h09);
        for (int i = 0; i < 4; i++) pop_check(8'(8'hF0 + i), "R6 queued byte");
        clear_flags();

        // Block Write, single-byte mode (R9).
        buf32_en = 1'b0;
        wr_reg(SEL_DATA0, 8'd3);
        wr_reg(SEL_BLOCK, 8'h61);
        expect_op(OP_START, 0, "R9 start"); expect_op(OP_WRITE, 8'hA0, "R9 addr");
        expect_op(OP_WRITE, 8'h3C, "R9 cmd"); expect_op(OP_WRITE, 8'd3, "R9 count");
        expect_op(OP_WRITE, 8'h61, "R9 data"); expect_op(OP_WRITE, 8'h62, "R9 data");
        expect_op(OP_WRITE, 8'h63, "R9 data"); expect_op(OP_STOP, 0, "R9 stop");
        start(PROTO_BWRITE);
        for (int i = 0; i < 2; i++) begin
            while (!irq) @(negedge clk);
            chk(busy && !done, "R9 stall for payload", {busy, done}, 2);
            wr_reg(SEL_BLOCK, 8'(8'h62 + i));
        end
        wait_idle();
        chk(exp_q.size() == 0 && done, "R9 byte-mode write done", exp_q.size(), 0);
        clear_flags();

        // Block Read, single-byte mode (R9).
        wr_reg(SEL_DATA0, 8'd2);
        rd_q.push_back(8'h02); rd_q.push_back(8'h71); rd_q.push_back(8'h72);
        expect_op(OP_START, 0, "R9 start"); expect_op(OP_WRITE, 8'hA0, "R9 addr w");
        expect_op(OP_WRITE, 8'h3C, "R9 cmd"); expect_op(OP_RSTART, 0, "R9 rstart");
        expect_op(OP_WRITE, 8'hA1, "R9 addr r"); expect_op(OP_RD_ACK, 0, "R9 count");
        expect_op(OP_RD_ACK, 0, "R9 data"); expect_op(OP_RD_NACK, 0, "R9 last");
        expect_op(OP_STOP, 0, "R9 stop");
        start(PROTO_BREAD);
        while (!irq) @(negedge clk);
        chk(busy, "R9 stall for read-out", busy, 1);
        pop_check(8'h71, "R9 first byte");
        while (!irq) @(negedge clk);
        wait_idle();
        chk(done, "R9 byte-mode read done", done, 1);
        pop_check(8'h72, "R9 second byte");
        chk(exp_q.size() == 0, "R9 read ops", exp_q.size(), 0);
        clear_flags();
        buf32_en = 1'b1;

        // Device NACK on the address byte (R10).
        nack_at = 0;
        wr_reg(SEL_DATA0, 8'h55);
        expect_op(OP_START, 0, "R10 start"); expect_op(OP_WRITE, 8'hA0, "R10 addr");
        expect_op(OP_STOP, 0, "R10 stop");
        start(PROTO_PCALL);
        wait_idle();
        chk(err && !done, "R10 abort flags", {err, done}, 2);
        chk(exp_q.size() == 0, "R10 abort ops", exp_q.size(), 0);
        chk(data0_q == 8'h55, "R10 data0 untouched", data0_q, 8'h55);
        nack_at = -1;
        clear_flags();

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R13 no pending ops", exp_q.size(), 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule